// File: doc/BRIEF.md
# Processor Power Rail Sequencer

This block drives the enables of the supply rails of an application processor and its active-low reset. It brings the rails up in stages from a powered-off state, and it supports two low-power states. A long press on the pushbutton starts the bring-up. The staged order is fixed: first the external regulator, then the pre-supply and core rails, then the two I/O rails once the pre-supply is good. Reset is released a fixed time after the 3.3 V rail reports good. The PLL rail follows a handshake pin from the processor.

Light sleep is driven by the same processor pin once software has cleared a mask bit. Deep sleep is entered through a register write and keeps only the 1.8 V memory rail alive. A later press brings the system back with the full bring-up. A memory-valid flag lives in the registers. It survives deep sleep and is lost on undervoltage, which returns every register to its default and forces the next start to be a cold one.

All delays are counted in milliseconds from a prescaler, which is set by the `CLKS_PER_MS` parameter. The register port is a plain single-cycle write strobe with a combinational read. It has no back-pressure: a write is always accepted in the cycle it is presented.

Top module: `pwr_rail_seq`

## Requirements
- R1: A press is recognised only after the synchronised pushbutton has stayed low for `DEBOUNCE_MS` milliseconds without a break. A shorter low pulse starts nothing. `key_n` is low exactly while a recognised press is held.
- R2: From off, a recognised press raises `en_ext_reg`. `EXT_DELAY_MS` milliseconds later, `en_ldo_pre` and `en_buck_core` rise together.
- R3: `en_buck_io33` and `en_buck_io18` rise in the cycle after `pg_ldo_pre` is seen high in the pre-supply stage.
- R4: `en_ldo_pll` is high only while the I/O rails are enabled and `proc_en` is high.
- R5: `rst_out_n` rises `RESET_DELAY_MS` milliseconds after `pg_buck_io33` is first seen high with the I/O rails on.
- R6: Control register (address 1) bit 0 is the core mask, and it resets to 1. While it is 1, `en_buck_core` follows the pre-supply stage. While it is 0, `en_buck_core` also requires `proc_en`, so `proc_en` low drops the core and PLL rails and leaves every other output unchanged.
- R7: Writing 1 to control bit 1 (deep sleep) while running leaves only `en_buck_io18` on and drives `rst_out_n` low.
- R8: In deep sleep, a recognised press clears control bit 1 and re-runs the bring-up from R2. `en_buck_io18` stays high throughout the wake.
- R9: Control bit 2 (memory valid) changes only by register write, and it keeps its value through deep sleep and wake.
- R10: `uvlo` high returns both registers to their defaults, turns every rail off and holds reset low. The next press then performs a cold start.
- R11: After a press has been recognised, another press is recognised only after the pushbutton has been seen high again. A button held through deep-sleep entry does not wake the block.
- R12: The sequence register (address 0) resets to 0x3C: bits [2:0] hold the buck code 100 and bits [5:3] hold the LDO code 111. While either field differs from its code, every rail enable is low and `rst_out_n` is low.
- R13: A write with `reg_wr` high updates the addressed register at the next clock edge. `reg_rdata` shows the register chosen by `reg_addr` in the same cycle, and the unused upper control bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| button_n | input | 1 | Pushbutton, low when pressed, asynchronous |
| proc_en | input | 1 | Processor enable handshake pin |
| uvlo | input | 1 | Undervoltage lockout flag |
| pg_ldo_pre | input | 1 | Power-good of the pre-supply LDO rail |
| pg_buck_io33 | input | 1 | Power-good of the 3.3 V I/O buck rail |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 sequence, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| key_n | output | 1 | Keypress indication, active low |
| en_ext_reg | output | 1 | External regulator enable |
| en_ldo_pre | output | 1 | Pre-supply LDO enable |
| en_buck_core | output | 1 | Core buck enable |
| en_buck_io33 | output | 1 | 3.3 V I/O buck enable |
| en_buck_io18 | output | 1 | 1.8 V I/O and memory buck enable |
| en_ldo_pll | output | 1 | PLL LDO enable |
| rst_out_n | output | 1 | Processor reset, active low |

## Verification
The bench targets four corner cases:
- A low pulse on the pushbutton shorter than the debounce window. A design that reset its counter wrongly would start on noise.
- A button held down through deep-sleep entry. A design that reacted to the button level instead of a fresh press would wake at once.
- A deep-sleep wake. The memory rail must not drop during the wake, and the deep bit must clear while memory-valid is kept.
- An undervoltage pulse after the flag is set. A design whose register reset was incomplete would report stale memory-valid data.

Light sleep is checked against both values of the mask. A bad sequence code is written while running, and the rails must fall and then return when the code is restored.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF, ST_EXT, ST_PRE, ST_IO, ST_RSTW, ST_RUN, ST_DEEP
  } seq_state_e;

  localparam int REG_DW = 8;
  localparam logic [2:0] BUCK_CODE = 3'b100;
  localparam logic [2:0] LDO_CODE  = 3'b111;
  localparam logic [REG_DW-1:0] SEQ_DEFAULT = {2'b00, LDO_CODE, BUCK_CODE};
  localparam logic [2:0] CTL_DEFAULT = 3'b001;
  localparam int CTL_MASK  = 0;
  localparam int CTL_DEEP  = 1;
  localparam int CTL_MEMOK = 2;

  function automatic int ms_width(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return $clog2(m + 1) + 1;
  endfunction
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int CLKS_PER_MS = 125000,
  parameter int MS_W        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            run,
  input  logic [MS_W-1:0] target_ms,
  output logic            done
);
  localparam int PRE_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;

  assign done = (ms_q == target_ms);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (clr) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (run && !done) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        ms_q  <= ms_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_seq_debounce.sv
module pwr_seq_debounce #(
  parameter int CLKS_PER_MS = 125000,
  parameter int MS_W        = 8,
  parameter int DEBOUNCE_MS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic button_n,
  output logic pressed,
  output logic press_evt
);
  logic [1:0] sync_q;
  logic       low_s;
  logic       prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ~button_n};
      prev_q <= pressed;
    end
  end

  assign low_s = sync_q[1];

  pwr_seq_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MS_W(MS_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (~low_s),
    .run       (1'b1),
    .target_ms (MS_W'(DEBOUNCE_MS)),
    .done      (pressed)
  );

  // A fresh press exists only on the rising edge of the debounced level,
  // so the button must be released before another one can be seen.
  assign press_evt = pressed & ~prev_q;
endmodule

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
  import pwr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uvlo,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              clr_deep,
  output logic [REG_DW-1:0] seq_q,
  output logic [2:0]        ctl_q,
  output logic [REG_DW-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SEQ_DEFAULT;
      ctl_q <= CTL_DEFAULT;
    end else if (uvlo) begin
      seq_q <= SEQ_DEFAULT;
      ctl_q <= CTL_DEFAULT;
    end else begin
      if (wr_en && !addr) seq_q <= wdata;
      if (wr_en && addr)  ctl_q <= wdata[2:0];
      if (clr_deep)       ctl_q[CTL_DEEP] <= 1'b0;
    end
  end

  assign rdata = addr ? {{(REG_DW-3){1'b0}}, ctl_q} : seq_q;
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int CLKS_PER_MS    = 125000,
  parameter int MS_W           = 8,
  parameter int EXT_DELAY_MS   = 1,
  parameter int RESET_DELAY_MS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uvlo,
  input  logic       press_evt,
  input  logic       pg_pre,
  input  logic       pg_io33,
  input  logic       deep_req,
  output seq_state_e state,
  output logic       wake,
  output logic       clr_deep
);
  seq_state_e st_q, st_d;
  logic       wake_q;
  logic       timed;
  logic       t_done;
  logic [MS_W-1:0] t_target;

  assign timed    = (st_q == ST_EXT) || (st_q == ST_RSTW);
  assign t_target = (st_q == ST_EXT) ? MS_W'(EXT_DELAY_MS) : MS_W'(RESET_DELAY_MS);

  pwr_seq_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MS_W(MS_W)) u_delay (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (uvlo | ~timed),
    .run       (timed),
    .target_ms (t_target),
    .done      (t_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:  if (press_evt) st_d = ST_EXT;
      ST_EXT:  if (t_done)    st_d = ST_PRE;
      ST_PRE:  if (pg_pre)    st_d = ST_IO;
      ST_IO:   if (pg_io33)   st_d = ST_RSTW;
      ST_RSTW: if (t_done)    st_d = ST_RUN;
      ST_RUN:  if (deep_req)  st_d = ST_DEEP;
      ST_DEEP: if (press_evt) st_d = ST_EXT;
      default:                st_d = ST_OFF;
    endcase
  end

  assign clr_deep = (st_q == ST_DEEP) && press_evt && !uvlo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      wake_q <= 1'b0;
    end else if (uvlo) begin
      st_q   <= ST_OFF;
      wake_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (clr_deep) wake_q <= 1'b1;
      else if (st_q == ST_PRE && pg_pre) wake_q <= 1'b0;
    end
  end

  assign state = st_q;
  assign wake  = wake_q;
endmodule

// File: rtl/pwr_seq_rails.sv
module pwr_seq_rails
  import pwr_seq_pkg::*;
(
  input  seq_state_e        state,
  input  logic              wake,
  input  logic              mask,
  input  logic              proc_en,
  input  logic              pressed,
  input  logic [REG_DW-1:0] seq_code,
  output logic              key_n,
  output logic              en_ext_reg,
  output logic              en_ldo_pre,
  output logic              en_buck_core,
  output logic              en_buck_io33,
  output logic              en_buck_io18,
  output logic              en_ldo_pll,
  output logic              rst_out_n
);
  logic codes_ok, ext_ph, pre_ph, io_ph, mem_hold;

  assign codes_ok = (seq_code[2:0] == BUCK_CODE) && (seq_code[5:3] == LDO_CODE);
  assign ext_ph   = state inside {ST_EXT, ST_PRE, ST_IO, ST_RSTW, ST_RUN};
  assign pre_ph   = state inside {ST_PRE, ST_IO, ST_RSTW, ST_RUN};
  assign io_ph    = state inside {ST_IO, ST_RSTW, ST_RUN};
  assign mem_hold = (state == ST_DEEP) || (wake && (state inside {ST_EXT, ST_PRE}));

  assign key_n        = ~pressed;
  assign en_ext_reg   = codes_ok & ext_ph;
  assign en_ldo_pre   = codes_ok & pre_ph;
  assign en_buck_core = codes_ok & pre_ph & (mask | proc_en);
  assign en_buck_io33 = codes_ok & io_ph;
  assign en_buck_io18 = codes_ok & (io_ph | mem_hold);
  assign en_ldo_pll   = codes_ok & io_ph & proc_en;
  assign rst_out_n    = codes_ok & (state == ST_RUN);
endmodule

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq
  import pwr_seq_pkg::*;
#(
  parameter int CLKS_PER_MS    = 125000,
  parameter int DEBOUNCE_MS    = 50,
  parameter int EXT_DELAY_MS   = 1,
  parameter int RESET_DELAY_MS = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        button_n,
  input  logic        proc_en,
  input  logic        uvlo,
  input  logic        pg_ldo_pre,
  input  logic        pg_buck_io33,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        key_n,
  output logic        en_ext_reg,
  output logic        en_ldo_pre,
  output logic        en_buck_core,
  output logic        en_buck_io33,
  output logic        en_buck_io18,
  output logic        en_ldo_pll,
  output logic        rst_out_n
);
  localparam int MS_W = ms_width(DEBOUNCE_MS, EXT_DELAY_MS, RESET_DELAY_MS);

  logic              pressed, press_evt, wake, clr_deep;
  seq_state_e        state;
  logic [REG_DW-1:0] seq_q;
  logic [2:0]        ctl_q;

  pwr_seq_debounce #(
    .CLKS_PER_MS(CLKS_PER_MS), .MS_W(MS_W), .DEBOUNCE_MS(DEBOUNCE_MS)
  ) u_deb (
    .clk       (clk),
    .rst_n     (rst_n),
    .button_n  (button_n),
    .pressed   (pressed),
    .press_evt (press_evt)
  );

  pwr_seq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .uvlo     (uvlo),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .clr_deep (clr_deep),
    .seq_q    (seq_q),
    .ctl_q    (ctl_q),
    .rdata    (reg_rdata)
  );

  pwr_seq_fsm #(
    .CLKS_PER_MS(CLKS_PER_MS), .MS_W(MS_W),
    .EXT_DELAY_MS(EXT_DELAY_MS), .RESET_DELAY_MS(RESET_DELAY_MS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .uvlo      (uvlo),
    .press_evt (press_evt),
    .pg_pre    (pg_ldo_pre),
    .pg_io33   (pg_buck_io33),
    .deep_req  (ctl_q[CTL_DEEP]),
    .state     (state),
    .wake      (wake),
    .clr_deep  (clr_deep)
  );

  pwr_seq_rails u_rails (
    .state        (state),
    .wake         (wake),
    .mask         (ctl_q[CTL_MASK]),
    .proc_en      (proc_en),
    .pressed      (pressed),
    .seq_code     (seq_q),
    .key_n        (key_n),
    .en_ext_reg   (en_ext_reg),
    .en_ldo_pre   (en_ldo_pre),
    .en_buck_core (en_buck_core),
    .en_buck_io33 (en_buck_io33),
    .en_buck_io18 (en_buck_io18),
    .en_ldo_pll   (en_ldo_pll),
    .rst_out_n    (rst_out_n)
  );
endmodule

// File: rtl/pwr_rail_seq_chk.sv
module pwr_rail_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic uvlo,
  input logic proc_en,
  input logic en_ext_reg,
  input logic en_ldo_pre,
  input logic en_buck_io33,
  input logic en_buck_io18,
  input logic en_ldo_pll,
  input logic rst_out_n
);
  // R4: the PLL rail needs both the I/O stage and the processor pin
  assert_pll_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_ldo_pll |-> (en_buck_io33 && proc_en));

  // R2: the pre-supply rail never runs without the external regulator
  assert_pre_after_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_ldo_pre |-> en_ext_reg);

  // R5: reset is released only with the main rails up
  assert_reset_rails_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_n |-> (en_buck_io33 && en_buck_io18 && en_ldo_pre));

  // R10: undervoltage drops everything on the next cycle
  assert_uvlo_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> (!en_ext_reg && !en_buck_io18 && !rst_out_n));
endmodule

bind pwr_rail_seq pwr_rail_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .uvlo         (uvlo),
  .proc_en      (proc_en),
  .en_ext_reg   (en_ext_reg),
  .en_ldo_pre   (en_ldo_pre),
  .en_buck_io33 (en_buck_io33),
  .en_buck_io18 (en_buck_io18),
  .en_ldo_pll   (en_ldo_pll),
  .rst_out_n    (rst_out_n)
);

// File: tb/pwr_rail_seq_test.sv
`timescale 1ns/1ps
module pwr_rail_seq_test;
  localparam int CPM = 4, DB_MS = 3, EXT_MS = 1, RST_MS = 2;
  localparam int DBC = DB_MS * CPM, EXTC = EXT_MS * CPM, RSTC = RST_MS * CPM;
  localparam int M_OFF = 0, M_EXT = 1, M_PRE = 2, M_IO = 3, M_RSTW = 4, M_RUN = 5, M_DEEP = 6;

  logic clk = 1'b0, rst_n = 1'b0, button_n = 1'b1, proc_en = 1'b0, uvlo = 1'b0;
  logic pg_ldo_pre = 1'b0, pg_buck_io33 = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic key_n, en_ext_reg, en_ldo_pre, en_buck_core, en_buck_io33, en_buck_io18, en_ldo_pll, rst_out_n;

  int checks = 0, fails = 0;
  bit chk_on = 1'b0;

  always #4 clk = ~clk;

  pwr_rail_seq #(.CLKS_PER_MS(CPM), .DEBOUNCE_MS(DB_MS), .EXT_DELAY_MS(EXT_MS),
                 .RESET_DELAY_MS(RST_MS)) uut (
    .clk(clk), .rst_n(rst_n), .button_n(button_n), .proc_en(proc_en), .uvlo(uvlo),
    .pg_ldo_pre(pg_ldo_pre), .pg_buck_io33(pg_buck_io33), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .key_n(key_n),
    .en_ext_reg(en_ext_reg), .en_ldo_pre(en_ldo_pre), .en_buck_core(en_buck_core),
    .en_buck_io33(en_buck_io33), .en_buck_io18(en_buck_io18), .en_ldo_pll(en_ldo_pll),
    .rst_out_n(rst_out_n));

  // Behavioural reference model
  bit m_s1, m_s2, m_pprev, m_wake;
  int m_db, m_st, m_t;
  logic [7:0] m_seq;
  logic [2:0] m_ctl;

  always @(posedge clk) begin
    bit pnow, evt, clr;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_db = 0; m_pprev = 0; m_st = M_OFF; m_t = 0;
      m_wake = 0; m_seq = 8'h3C; m_ctl = 3'b001;
    end else begin
      pnow = (m_db == DBC);
      evt = pnow && !m_pprev;
      m_pprev = pnow;
      if (!m_s2) m_db = 0; else if (m_db < DBC) m_db++;
      m_s2 = m_s1; m_s1 = !button_n;
      if (uvlo) begin
        m_st = M_OFF; m_t = 0; m_wake = 0; m_seq = 8'h3C; m_ctl = 3'b001;
      end else begin
        clr = 0;
        if (!(m_st == M_EXT || m_st == M_RSTW)) m_t = 0;
        case (m_st)
          M_OFF:  if (evt) m_st = M_EXT;
          M_EXT:  if (m_t == EXTC) m_st = M_PRE; else m_t++;
          M_PRE:  if (pg_ldo_pre) begin m_st = M_IO; m_wake = 0; end
          M_IO:   if (pg_buck_io33) m_st = M_RSTW;
          M_RSTW: if (m_t == RSTC) m_st = M_RUN; else m_t++;
          M_RUN:  if (m_ctl[1]) m_st = M_DEEP;
          default: if (evt) begin m_st = M_EXT; m_wake = 1; clr = 1; end
        endcase
        if (reg_wr) begin
          if (reg_addr) m_ctl = reg_wdata[2:0]; else m_seq = reg_wdata;
        end
        if (clr) m_ctl[1] = 1'b0;
      end
    end
  end

  task automatic cmp(string tag, string nm, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual=%0h expected=%0h", tag, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit ok, io, pre, ext;
    if (chk_on) begin
      ok  = (m_seq[2:0] == 3'b100) && (m_seq[5:3] == 3'b111);
      ext = m_st inside {M_EXT, M_PRE, M_IO, M_RSTW, M_RUN};
      pre = m_st inside {M_PRE, M_IO, M_RSTW, M_RUN};
      io  = m_st inside {M_IO, M_RSTW, M_RUN};
      cmp("R1", "key_n", 8'(key_n), 8'(!(m_db == DBC)));
      cmp("R2", "en_ext_reg", 8'(en_ext_reg), 8'(ok && ext));
      cmp("R2", "en_ldo_pre", 8'(en_ldo_pre), 8'(ok && pre));
      cmp("R6", "en_buck_core", 8'(en_buck_core), 8'(ok && pre && (m_ctl[0] || proc_en)));
      cmp("R3", "en_buck_io33", 8'(en_buck_io33), 8'(ok && io));
      cmp("R8", "en_buck_io18", 8'(en_buck_io18),
          8'(ok && (io || m_st == M_DEEP || (m_wake && (m_st == M_EXT || m_st == M_PRE)))));
      cmp("R4", "en_ldo_pll", 8'(en_ldo_pll), 8'(ok && io && proc_en));
      cmp("R5", "rst_out_n", 8'(rst_out_n), 8'(ok && m_st == M_RUN));
      cmp("R13", "reg_rdata", reg_rdata, reg_addr ? {5'b0, m_ctl} : m_seq);
    end
  end

  task automatic adv(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    adv(1);
    reg_wr = 1'b0;
  endtask

  task automatic expect_bit(string tag, string nm, logic act, logic exp);
    @(negedge clk);
    cmp(tag, nm, 8'(act), 8'(exp));
    @(posedge clk); #1;
  endtask

  task automatic run_all();
    adv(3);
    rst_n = 1'b1;
    chk_on = 1'b1;
    reg_addr = 1'b0;
    @(negedge clk); cmp("R12", "seq default", reg_rdata, 8'h3C);
    reg_addr = 1'b1;
    @(negedge clk); cmp("R6", "ctrl default", reg_rdata, 8'h01);
    adv(1);
    // short glitch must not start
    button_n = 1'b0; adv(8); button_n = 1'b1; adv(20);
    expect_bit("R1", "glitch no start", en_ext_reg, 1'b0);
    // real press
    button_n = 1'b0; adv(20);
    expect_bit("R1", "key_n held", key_n, 1'b0);
    expect_bit("R2", "ext on", en_ext_reg, 1'b1);
    button_n = 1'b1; adv(10);
    expect_bit("R2", "core on", en_buck_core, 1'b1);
    expect_bit("R3", "io33 waits pg", en_buck_io33, 1'b0);
    pg_ldo_pre = 1'b1; adv(2);
    expect_bit("R3", "io18 on", en_buck_io18, 1'b1);
    expect_bit("R4", "pll waits proc", en_ldo_pll, 1'b0);
    proc_en = 1'b1; adv(1);
    expect_bit("R4", "pll on", en_ldo_pll, 1'b1);
    pg_buck_io33 = 1'b1; adv(4);
    expect_bit("R5", "reset still low", rst_out_n, 1'b0);
    adv(10);
    expect_bit("R5", "reset released", rst_out_n, 1'b1);
    // light sleep with mask cleared
    wr(1'b1, 8'h00);
    proc_en = 1'b0; adv(2);
    expect_bit("R6", "core off", en_buck_core, 1'b0);
    expect_bit("R6", "io33 kept", en_buck_io33, 1'b1);
    proc_en = 1'b1; adv(1);
    expect_bit("R6", "core back", en_buck_core, 1'b1);
    // memory valid
    wr(1'b1, 8'h04);
    reg_addr = 1'b1;
    @(negedge clk); cmp("R9", "memvalid set", reg_rdata, 8'h04); adv(1);
    // hold button through deep entry
    button_n = 1'b0; adv(20);
    wr(1'b1, 8'h06); adv(2);
    expect_bit("R7", "io33 off in deep", en_buck_io33, 1'b0);
    expect_bit("R7", "io18 kept", en_buck_io18, 1'b1);
    expect_bit("R7", "reset low", rst_out_n, 1'b0);
    pg_ldo_pre = 1'b0; pg_buck_io33 = 1'b0; adv(30);
    expect_bit("R11", "held button no wake", en_ext_reg, 1'b0);
    // fresh press wakes
    button_n = 1'b1; adv(5); button_n = 1'b0; adv(20);
    expect_bit("R8", "wake ext on", en_ext_reg, 1'b1);
    expect_bit("R8", "mem rail kept", en_buck_io18, 1'b1);
    reg_addr = 1'b1;
    @(negedge clk); cmp("R9", "deep cleared memvalid kept", reg_rdata, 8'h04); adv(1);
    button_n = 1'b1; adv(10);
    pg_ldo_pre = 1'b1; adv(2);
    pg_buck_io33 = 1'b1; adv(15);
    expect_bit("R8", "reset after wake", rst_out_n, 1'b1);
    // bad sequence code
    wr(1'b0, 8'h3D);
    expect_bit("R12", "bad code rail off", en_buck_io18, 1'b0);
    expect_bit("R12", "bad code reset", rst_out_n, 1'b0);
    wr(1'b0, 8'h3C);
    expect_bit("R12", "code restored", rst_out_n, 1'b1);
    // undervoltage
    uvlo = 1'b1; adv(1); uvlo = 1'b0;
    expect_bit("R10", "uvlo rails off", en_buck_io18, 1'b0);
    reg_addr = 1'b1;
    @(negedge clk); cmp("R10", "ctrl defaults", reg_rdata, 8'h01); adv(1);
    button_n = 1'b0; adv(45); button_n = 1'b1;
    expect_bit("R10", "cold start reset", rst_out_n, 1'b1);
    adv(5);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule